// File: doc/BRIEF.md
# UART Status Flag and Interrupt Controller

This block keeps the seven status flags of a double-buffered UART and turns them into interrupt requests. A transmit engine and a receive engine report what happens on the line as one-cycle event pulses: a byte has moved into the transmit shifter, the shifter is busy, a received frame is complete, the line went idle, the frame carried noise, or the frame had a bad stop bit. The flags are set from these pulses. They are cleared only by a two-step software sequence. First the status register is read while the flag is set. Then the data register is accessed: a write clears the transmit flags, and a read clears the receive flags.

Software sees the flags as one read-only byte on a simple register bus that has an address, a read strobe and a write strobe. The block decodes the status address and the data-register address. It also gives the receive data register a capture strobe, so that a frame arriving while the previous byte is still unread is dropped and flagged as an overrun. Four enable bits from the control register gate the flags onto four interrupt lines.

Top module: `uart_flag_ctrl`

## Requirements
- R1: Synchronous active-high reset leaves the status byte at 0xC0. The transmit-empty flag (bit 7) and the transmit-complete flag (bit 6) are 1, and the other flags are 0.
- R2: While the status address is read, `bus_rdata` gives {tx-empty[7], tx-complete[6], rx-full[5], line-idle[4], overrun[3], noise[2], frame-error[1], 0[0]}. In every other cycle it is 0x00, including reads of any other address.
- R3: Writes to the status address, or to any address other than the data register, change no flag.
- R4: `ev_tx_load` sets the transmit-empty flag at the next clock edge.
- R5: The transmit-complete flag is set at an edge where the transmit-empty flag will be 1 and `tx_busy` is 0. While `tx_busy` is 1 it does not rise.
- R6: The transmit-empty and transmit-complete flags are cleared by a data-register write only if a status read saw them set. A write with no prior status read leaves them unchanged. A set event in the same cycle as the clearing write wins.
- R7: When `ev_rx_done` arrives with the rx-full flag at 0, `rx_load` is 1 in that cycle and rx-full is set at the next edge.
- R8: When `ev_rx_done` arrives with rx-full at 1, `rx_load` stays 0 (the older byte is kept) and the overrun flag is set.
- R9: `ev_rx_idle`, `ev_rx_noise` and `ev_rx_ferr` set the line-idle, noise and frame-error flags.
- R10: The receive flags are cleared by a data-register read only if a status read saw them set. A receive flag that rises after the status read survives the data read.
- R11: `irq_tx` = tx-empty AND `ie_tx`. `irq_tc` = tx-complete AND `ie_tc`. `irq_rx` = (rx-full OR overrun) AND `ie_rx`. `irq_idle` = line-idle AND `ie_idle`.
- R12: A data-register access uses up the record left by the status read. A second access without a new status read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Status byte during a status read, else 0 |
| ev_tx_load | input | 1 | Transmit holding byte moved into the shifter |
| tx_busy | input | 1 | Shifter is sending data, preamble or break |
| ev_rx_done | input | 1 | Received frame complete |
| ev_rx_idle | input | 1 | Receive line idle detected |
| ev_rx_noise | input | 1 | Noise seen in the frame |
| ev_rx_ferr | input | 1 | Stop bit missing |
| ie_tx | input | 1 | Transmit-empty interrupt enable |
| ie_tc | input | 1 | Transmit-complete interrupt enable |
| ie_rx | input | 1 | Receive interrupt enable |
| ie_idle | input | 1 | Idle-line interrupt enable |
| rx_load | output | 1 | Capture strobe for the receive data register |
| irq_tx | output | 1 | Transmit-empty interrupt request |
| irq_tc | output | 1 | Transmit-complete interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_idle | output | 1 | Idle-line interrupt request |

## Verification
A wrong flag shows up in the very next status read and, through the combinational gating, on the matching interrupt line in the same cycle. A wrong status-read record stays hidden until the next data-register access. At that access the flag either clears when it should not, or survives when it should have cleared, and the following status read shows the difference. The bench therefore follows every clearing sequence with a status read. It sweeps all sixteen enable combinations across several flag states, and all addresses for the write and read decode.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef struct packed {
        logic tdre;
        logic tc;
        logic rdrf;
        logic idle;
        logic ovr;
        logic nf;
        logic fe;
    } flags_t;

    localparam flags_t FLAGS_RST = 7'b1100000;

    typedef struct packed {
        logic stat_rd;
        logic stat_wr;
        logic data_rd;
        logic data_wr;
    } acc_t;

    typedef struct packed {
        logic rdrf;
        logic idle;
        logic ovr;
        logic nf;
        logic fe;
    } rxf_t;

    function automatic logic [7:0] status_byte(flags_t f);
        return {f, 1'b0};
    endfunction

endpackage

// File: rtl/ufc_decode.sv
module ufc_decode
    import ufc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4'hD,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 4'hF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output acc_t              acc
);
    logic hit_stat, hit_data;

    always_comb begin
        hit_stat     = (addr == STAT_ADDR);
        hit_data     = (addr == DATA_ADDR);
        acc.stat_rd  = rd && hit_stat;
        acc.stat_wr  = wr && hit_stat;
        acc.data_rd  = rd && hit_data;
        acc.data_wr  = wr && hit_data;
    end
endmodule

// File: rtl/ufc_tx_flags.sv
module ufc_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic ev_load,
    input  logic busy,
    input  logic stat_rd,
    input  logic data_wr,
    output logic tdre,
    output logic tc
);
    logic arm_tdre, arm_tc;
    logic tdre_nxt, tc_nxt;

    always_comb begin
        tdre_nxt = tdre;
        if (ev_load)
            tdre_nxt = 1'b1;
        else if (data_wr && arm_tdre)
            tdre_nxt = 1'b0;

        tc_nxt = tc;
        if (tdre_nxt && !busy)
            tc_nxt = 1'b1;
        else if (data_wr && arm_tc)
            tc_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tdre     <= 1'b1;
            tc       <= 1'b1;
            arm_tdre <= 1'b0;
            arm_tc   <= 1'b0;
        end else begin
            tdre <= tdre_nxt;
            tc   <= tc_nxt;
            if (stat_rd) begin
                arm_tdre <= tdre;
                arm_tc   <= tc;
            end else if (data_wr) begin
                arm_tdre <= 1'b0;
                arm_tc   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ufc_rx_flags.sv
module ufc_rx_flags
    import ufc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_done,
    input  logic ev_idle,
    input  logic ev_noise,
    input  logic ev_ferr,
    input  logic stat_rd,
    input  logic data_rd,
    output rxf_t rxf,
    output logic load
);
    rxf_t arm, set_v, clr_v;

    always_comb begin
        load       = ev_done && !rxf.rdrf;
        set_v.rdrf = load;
        set_v.ovr  = ev_done && rxf.rdrf;
        set_v.idle = ev_idle;
        set_v.nf   = ev_noise;
        set_v.fe   = ev_ferr;
        clr_v      = data_rd ? arm : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxf <= '0;
            arm <= '0;
        end else begin
            rxf <= set_v | (rxf & ~clr_v);
            if (stat_rd)
                arm <= rxf;
            else if (data_rd)
                arm <= '0;
        end
    end
endmodule

// File: rtl/ufc_irq.sv
module ufc_irq
    import ufc_pkg::*;
(
    input  flags_t flags,
    input  logic   ie_tx,
    input  logic   ie_tc,
    input  logic   ie_rx,
    input  logic   ie_idle,
    output logic   irq_tx,
    output logic   irq_tc,
    output logic   irq_rx,
    output logic   irq_idle
);
    always_comb begin
        irq_tx   = ie_tx && flags.tdre;
        irq_tc   = ie_tc && flags.tc;
        irq_rx   = ie_rx && (flags.rdrf || flags.ovr);
        irq_idle = ie_idle && flags.idle;
    end
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
    import ufc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4'hD,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 4'hF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    input  logic              ev_tx_load,
    input  logic              tx_busy,
    input  logic              ev_rx_done,
    input  logic              ev_rx_idle,
    input  logic              ev_rx_noise,
    input  logic              ev_rx_ferr,
    input  logic              ie_tx,
    input  logic              ie_tc,
    input  logic              ie_rx,
    input  logic              ie_idle,
    output logic              rx_load,
    output logic              irq_tx,
    output logic              irq_tc,
    output logic              irq_rx,
    output logic              irq_idle
);
    acc_t   acc;
    rxf_t   rxf;
    flags_t flags;
    logic   tdre, tc;

    ufc_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .acc(acc)
    );

    ufc_tx_flags u_tx (
        .clk(clk), .rst(rst), .ev_load(ev_tx_load), .busy(tx_busy),
        .stat_rd(acc.stat_rd), .data_wr(acc.data_wr),
        .tdre(tdre), .tc(tc)
    );

    ufc_rx_flags u_rx (
        .clk(clk), .rst(rst), .ev_done(ev_rx_done), .ev_idle(ev_rx_idle),
        .ev_noise(ev_rx_noise), .ev_ferr(ev_rx_ferr),
        .stat_rd(acc.stat_rd), .data_rd(acc.data_rd),
        .rxf(rxf), .load(rx_load)
    );

    always_comb begin
        flags.tdre = tdre;
        flags.tc   = tc;
        flags.rdrf = rxf.rdrf;
        flags.idle = rxf.idle;
        flags.ovr  = rxf.ovr;
        flags.nf   = rxf.nf;
        flags.fe   = rxf.fe;
        bus_rdata  = acc.stat_rd ? status_byte(flags) : 8'h00;
    end

    // Status-address writes are decoded but deliberately have no effect.
    logic unused_ok;
    assign unused_ok = acc.stat_wr;

    ufc_irq u_irq (
        .flags(flags), .ie_tx(ie_tx), .ie_tc(ie_tc), .ie_rx(ie_rx),
        .ie_idle(ie_idle), .irq_tx(irq_tx), .irq_tc(irq_tc),
        .irq_rx(irq_rx), .irq_idle(irq_idle)
    );
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker
    import ufc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4'hD,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 4'hF
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              ev_tx_load,
    input logic              tx_busy,
    input logic              ev_rx_done,
    input logic              ev_rx_idle,
    input logic              ev_rx_noise,
    input logic              ev_rx_ferr,
    input logic              rx_load,
    input flags_t            flags
);
    logic quiet;
    assign quiet = !ev_tx_load && !ev_rx_done && !ev_rx_idle && !ev_rx_noise && !ev_rx_ferr;

    AST_RESET_VALUES: assert property (@(posedge clk) rst |=> (flags == FLAGS_RST)); // R1

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 8'h00)); // R2

    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != DATA_ADDR && quiet) |=> $stable(flags)); // R3

    AST_TDRE_SET: assert property (@(posedge clk) disable iff (rst)
        ev_tx_load |=> flags.tdre); // R4

    AST_TC_RISE: assert property (@(posedge clk) disable iff (rst)
        (!flags.tc && tx_busy) |=> !flags.tc); // R5

    AST_RDRF_SET: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_done && !flags.rdrf) |-> rx_load); // R7

    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_done && flags.rdrf) |-> !rx_load); // R8

    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_done && flags.rdrf && !(bus_rd && bus_addr == STAT_ADDR)) |=> flags.ovr); // R8

    AST_IDLE_SET: assert property (@(posedge clk) disable iff (rst)
        ev_rx_idle |=> flags.idle); // R9
endmodule

bind uart_flag_ctrl ufc_checker #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (.*);

// File: tb/sim_uart_flag_ctrl.sv
`timescale 1ns/1ps
module sim_uart_flag_ctrl;
    localparam logic [3:0] STAT = 4'hD;
    localparam logic [3:0] DATA = 4'hF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic bus_rd = 0, bus_wr = 0;
    logic [7:0] bus_rdata;
    logic ev_tx_load = 0, tx_busy = 0, ev_rx_done = 0, ev_rx_idle = 0;
    logic ev_rx_noise = 0, ev_rx_ferr = 0;
    logic ie_tx = 0, ie_tc = 0, ie_rx = 0, ie_idle = 0;
    logic rx_load, irq_tx, irq_tc, irq_rx, irq_idle;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_flag_ctrl u0 (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd_status(input logic [7:0] exp, input string req);
        bus_addr = STAT; bus_rd = 1;
        #1 chk(req, bus_rdata, exp);
        step();
        bus_rd = 0;
    endtask

    task automatic wr(input logic [3:0] a);
        bus_addr = a; bus_wr = 1;
        step();
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        bus_addr = a; bus_rd = 1;
        step();
        bus_rd = 0;
    endtask

    // mask = {idle, rx-full|overrun, tx-complete, tx-empty}
    task automatic irq_sweep(input logic [3:0] mask);
        for (int e = 0; e < 16; e++) begin
            {ie_idle, ie_rx, ie_tc, ie_tx} = 4'(e);
            #1 chk("R11 irq", {4'h0, irq_idle, irq_rx, irq_tc, irq_tx}, {4'h0, 4'(e) & mask});
        end
        {ie_idle, ie_rx, ie_tc, ie_tx} = 4'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 0;
        // R1: reset state seen through interrupts (no bus access yet)
        irq_sweep(4'b0011);
        // R3 / R6: writes everywhere with no prior status read change nothing
        for (int a = 0; a < 16; a++) wr(4'(a));
        // R2: reads of other addresses return zero
        for (int a = 0; a < 16; a++) begin
            if (4'(a) != STAT) begin
                bus_addr = 4'(a); bus_rd = 1;
                #1 chk("R2 rdata non-status", bus_rdata, 8'h00);
                step(); bus_rd = 0;
            end
        end
        #1 chk("R2 rdata idle", bus_rdata, 8'h00);
        rd_status(8'hC0, "R1 R3 reset value kept");
        wr(DATA);
        rd_status(8'h00, "R6 clear tx flags");
        // R4 / R5: load while shifter busy
        tx_busy = 1; ev_tx_load = 1; step(); ev_tx_load = 0;
        rd_status(8'h80, "R4 tdre set");
        step(); step();
        rd_status(8'h80, "R5 tc held while busy");
        tx_busy = 0; step();
        rd_status(8'hC0, "R5 tc set when idle");
        wr(DATA);
        rd_status(8'h00, "R6 clear again");
        ev_tx_load = 1; step(); ev_tx_load = 0;
        rd_status(8'hC0, "R4 R5 load with idle shifter");
        bus_addr = DATA; bus_wr = 1; ev_tx_load = 1; step(); bus_wr = 0; ev_tx_load = 0;
        rd_status(8'hC0, "R6 set wins over clear");
        wr(DATA);
        ev_tx_load = 1; step(); ev_tx_load = 0;
        wr(DATA);
        rd_status(8'hC0, "R12 second write without status read");
        // Receive side
        ev_rx_done = 1;
        #1 chk("R7 rx_load", {7'h0, rx_load}, 8'h01);
        step(); ev_rx_done = 0;
        rd_status(8'hE0, "R7 rdrf set");
        ev_rx_done = 1;
        #1 chk("R8 rx_load suppressed", {7'h0, rx_load}, 8'h00);
        step(); ev_rx_done = 0;
        rd_status(8'hE8, "R8 overrun set");
        ev_rx_noise = 1; ev_rx_ferr = 1; step(); ev_rx_noise = 0; ev_rx_ferr = 0;
        rd_status(8'hEE, "R9 noise and frame error");
        ev_rx_idle = 1; step(); ev_rx_idle = 0;
        rd_status(8'hFE, "R9 idle");
        irq_sweep(4'b1111);
        rd(DATA);
        rd_status(8'hC0, "R10 rx flags cleared");
        rd(DATA);
        rd_status(8'hC0, "R12 data read alone");
        ev_rx_ferr = 1; step(); ev_rx_ferr = 0;
        rd_status(8'hC2, "R9 frame error");
        ev_rx_idle = 1; step(); ev_rx_idle = 0;
        rd(DATA);
        rd_status(8'hD0, "R10 late idle survives");
        ev_rx_done = 1; step(); ev_rx_done = 0;
        rd_status(8'hF0, "R7 rdrf again");
        ev_rx_done = 1; step(); ev_rx_done = 0;
        rd(DATA);
        rd_status(8'hC8, "R10 late overrun survives");
        irq_sweep(4'b0111);
        wr(STAT);
        rd_status(8'hC8, "R3 status write ignored");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule